// File: doc/BRIEF.md
# Multi-Core Interrupt Mailbox Register Block

This block is a memory-mapped controller through which cores send interrupts to each other. It serves sixteen cores, grouped as four nodes of four. Every core owns a small register window with four registers. The status word holds pending interrupt bits, which a sender raises through a write-to-set port and the receiver drops through a write-to-clear port. The enable word is a plain stored value. Each core also has a 32-byte mailbox that a sender fills with a message before it raises the interrupt.

Requests arrive on a simple single-cycle bus carrying a valid bit, a direction bit, a size bit, an address and 64 bits of write data. At most one request is taken per cycle, in order. Reads answer one cycle later with a valid strobe. An access that is misaligned, that hits an undecoded offset or that falls outside the window raises an error strobe for one cycle and changes nothing. Each core has one interrupt output.

Top module: `ipi_mailbox_top`

## Requirements
- R1: After reset every status word, enable word and mailbox entry reads as zero, all interrupt lines are low, and neither rspValid nor rspErr is high.
- R2: The target core index is node*4 + core, where node = reqAddr[45:44] and core = reqAddr[9:8]. That index also selects the interrupt bit irq[index]. reqAddr[43:10] must equal the WIN_BASE parameter (default 0), or else the access is an error.
- R3: A good write to offset 0x08 ORs reqWdata[31:0] into the target's status and drives its interrupt line high, even when the data is zero.
- R4: A good write to offset 0x0C sets status to status AND NOT reqWdata[31:0]. The interrupt line goes low only when the new status is zero and otherwise keeps its value.
- R5: A write to the status offset 0x00 has no effect. Reads of offsets 0x08 and 0x0C return zero. A read of status returns the 32-bit word zero-extended to 64 bits.
- R6: A write to offset 0x04 stores reqWdata[31:0] as the enable word, and a read returns it zero-extended. The enable word never changes any interrupt line.
- R7: Offsets 0x20 to 0x3F address four 64-bit mailbox entries, with entry number (offset-0x20)/8. reqSize encodes the access size: 0 means 4 bytes and 1 means 8 bytes. An 8-byte access reads or writes the whole entry. A 4-byte access uses bits [63:32] when offset bit 2 is set and bits [31:0] otherwise, leaves the other half untouched, and reads back zero-extended.
- R8: An 8-byte access needs offset[2:0]=0 and a 4-byte access needs offset[1:0]=0. A misaligned access raises rspErr, changes no state, and as a read returns zero.
- R9: Any offset other than 0x00, 0x04, 0x08, 0x0C and 0x20 to 0x3F is an error, as is any access outside the window. Such an access raises rspErr for one cycle, changes no state, and as a read returns zero data.
- R10: Every read answers in the next cycle with rspValid high. Writes never raise rspValid. rspErr follows any bad request in the next cycle. Back-to-back requests take effect in order, so a set followed at once by a clear of the same bits ends with status zero and the interrupt line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 1 | 0 = 4-byte, 1 = 8-byte access |
| reqAddr | input | ADDR_W (46) | Byte address |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after a read |
| rspErr | output | 1 | Bad access flag, one cycle after the request |
| rspData | output | 64 | Read data |
| irq | output | 16 | One interrupt line per core |

## Verification
The set/clear logic is tried in several ways: a set with zero data, sets that accumulate over several writes, a clear that removes only some bits, and a final clear that removes the rest. Together these show whether the line follows each set write or follows the status contents, and whether a clear drops the line too early. Mailbox traffic mixes whole-entry writes with writes to either half, which exposes a wrong half select or a write that spills into the neighbouring half. Alignment, unknown offsets and addresses outside the window are mixed into a long seeded random stream over all sixteen cores. This catches index mapping faults between the node and core fields, and any error access that still changes state.

// File: rtl/ipi_mailbox_pkg.sv
package ipi_mailbox_pkg;
  localparam int NODE_W    = 2;
  localparam int CORE_W    = 2;
  localparam int IDX_W     = NODE_W + CORE_W;
  localparam int NCORES    = 1 << IDX_W;
  localparam int SLOT_W    = 2;
  localparam int MBX_SLOTS = 1 << SLOT_W;
  localparam int REG_W     = 32;
  localparam int DATA_W    = 64;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic              setWr;
    logic              clrWr;
    logic              enWr;
    logic              mbxWr;
    logic              rdStat;
    logic              rdEn;
    logic              rdMbx;
    logic              wide;
    logic              upper;
    logic [IDX_W-1:0]  idx;
    logic [SLOT_W-1:0] slot;
  } ipiStrobe_t;
endpackage

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
  import ipi_mailbox_pkg::*;
#(
  parameter int ADDR_W = 46,
  parameter logic [ADDR_W-13:0] WIN_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output ipiStrobe_t        stb,
  output logic              rspValid,
  output logic              rspErr
);
  localparam int OFF_W = 8;

  logic [OFF_W-1:0] off;
  logic winHit, misal, hitStat, hitEn, hitSet, hitClr, hitMbx, known, good;

  always_comb begin
    off     = reqAddr[OFF_W-1:0];
    winHit  = (reqAddr[ADDR_W-3:10] == WIN_BASE);
    misal   = reqSize ? (off[2:0] != 3'd0) : (off[1:0] != 2'd0);
    hitStat = (off == 8'h00);
    hitEn   = (off == 8'h04);
    hitSet  = (off == 8'h08);
    hitClr  = (off == 8'h0C);
    hitMbx  = (off[7:5] == 3'b001);
    known   = winHit & (hitStat | hitEn | hitSet | hitClr | hitMbx);
    good    = reqValid & known & ~misal;

    stb       = '0;
    stb.idx   = {reqAddr[ADDR_W-1 -: NODE_W], reqAddr[8 +: CORE_W]};
    stb.slot  = off[4:3];
    stb.upper = off[2];
    stb.wide  = reqSize;
    if (good) begin
      if (reqWrite) begin
        stb.setWr = hitSet;
        stb.clrWr = hitClr;
        stb.enWr  = hitEn;
        stb.mbxWr = hitMbx;
      end else begin
        stb.rdStat = hitStat;
        stb.rdEn   = hitEn;
        stb.rdMbx  = hitMbx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid & ~reqWrite;
      rspErr   <= reqValid & ~(known & ~misal);
    end
  end
endmodule

// File: rtl/ipi_mailbox_dp.sv
module ipi_mailbox_dp
  import ipi_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ipiStrobe_t        stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rspData,
  output logic [NCORES-1:0] irq
);
  logic [NCORES-1:0][REG_W-1:0]                  statusVec;
  logic [NCORES-1:0][REG_W-1:0]                  enableVec;
  logic [NCORES-1:0][MBX_SLOTS-1:0][DATA_W-1:0]  mbxVec;

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    logic [REG_W-1:0]                 stQ, enQ, clrRes;
    logic                             irqQ, hit;
    logic [MBX_SLOTS-1:0][DATA_W-1:0] boxQ;

    assign hit    = (stb.idx == IDX_W'(g));
    assign clrRes = stQ & ~wdata[REG_W-1:0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ  <= '0;
        enQ  <= '0;
        irqQ <= 1'b0;
        boxQ <= '0;
      end else if (hit) begin
        if (stb.setWr) begin
          stQ  <= stQ | wdata[REG_W-1:0];
          irqQ <= 1'b1;
        end
        if (stb.clrWr) begin
          stQ <= clrRes;
          if (clrRes == '0) irqQ <= 1'b0;
        end
        if (stb.enWr) enQ <= wdata[REG_W-1:0];
        if (stb.mbxWr) begin
          if (stb.wide)       boxQ[stb.slot]                <= wdata;
          else if (stb.upper) boxQ[stb.slot][DATA_W-1:REG_W] <= wdata[REG_W-1:0];
          else                boxQ[stb.slot][REG_W-1:0]      <= wdata[REG_W-1:0];
        end
      end
    end

    assign statusVec[g] = stQ;
    assign enableVec[g] = enQ;
    assign mbxVec[g]    = boxQ;
    assign irq[g]       = irqQ;
  end

  logic [DATA_W-1:0] entry, rdNext;

  always_comb begin
    entry  = mbxVec[stb.idx][stb.slot];
    rdNext = '0;
    if (stb.rdStat) rdNext = DATA_W'(statusVec[stb.idx]);
    if (stb.rdEn)   rdNext = DATA_W'(enableVec[stb.idx]);
    if (stb.rdMbx) begin
      if (stb.wide)       rdNext = entry;
      else if (stb.upper) rdNext = DATA_W'(entry[DATA_W-1:REG_W]);
      else                rdNext = DATA_W'(entry[REG_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspData <= '0;
    else       rspData <= rdNext;
  end
endmodule

// File: rtl/ipi_mailbox_top.sv
module ipi_mailbox_top
  import ipi_mailbox_pkg::*;
#(
  parameter int ADDR_W = 46,
  parameter logic [ADDR_W-13:0] WIN_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic [NCORES-1:0] irq
);
  ipiStrobe_t stb;

  ipi_mailbox_ctrl #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .stb(stb),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  ipi_mailbox_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(reqWdata),
    .rspData(rspData), .irq(irq)
  );
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk
  import ipi_mailbox_pkg::*;
#(
  parameter int ADDR_W = 46,
  parameter logic [ADDR_W-13:0] WIN_BASE = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqSize,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspErr,
  input logic [DATA_W-1:0] rspData,
  input logic [NCORES-1:0] irq
);
  logic             inWin, setNow, zeroRdNow, lastSet, lastZeroRd;
  logic [IDX_W-1:0] nowIdx, lastIdx;

  assign inWin     = (reqAddr[ADDR_W-3:10] == WIN_BASE);
  assign nowIdx    = {reqAddr[ADDR_W-1 -: NODE_W], reqAddr[9:8]};
  assign setNow    = reqValid && reqWrite && inWin && reqAddr[7:0] == 8'h08 &&
                     (!reqSize || reqAddr[2:0] == 3'd0);
  assign zeroRdNow = reqValid && !reqWrite && inWin &&
                     (reqAddr[7:0] == 8'h08 || (reqAddr[7:0] == 8'h0C && !reqSize));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSet    <= 1'b0;
      lastZeroRd <= 1'b0;
      lastIdx    <= '0;
    end else begin
      lastSet    <= setNow;
      lastZeroRd <= zeroRdNow;
      lastIdx    <= nowIdx;
    end
  end

  assert_read_resp_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);
  assert_write_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> !rspValid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspErr));
  assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rstN)
    lastSet |-> irq[lastIdx]);
  assert_rise_needs_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((irq & ~$past(irq)) != '0) |-> lastSet);
  assert_err_no_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (irq == $past(irq)));
  assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspErr && rspValid) |-> (rspData == '0));
  assert_setclr_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    lastZeroRd |-> (rspData == '0));
endmodule

bind ipi_mailbox_top ipi_mailbox_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqSize(reqSize), .reqAddr(reqAddr), .rspValid(rspValid),
  .rspErr(rspErr), .rspData(rspData), .irq(irq)
);

// File: tb/ipi_mailbox_top_tb.sv
module ipi_mailbox_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSize = 1'b0;
  logic [45:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic        rspValid, rspErr;
  logic [63:0] rspData;
  logic [15:0] irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mStat [16];
  logic [31:0] mEn   [16];
  logic [63:0] mMbx  [64];
  logic [15:0] mIrq;

  ipi_mailbox_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [45:0] mk(int n, int c, int off);
    return {n[1:0], 34'd0, c[1:0], off[7:0]};
  endfunction

  // 0 bad, 1 status, 2 enable, 3 set, 4 clear, 5 mailbox
  function automatic int kindOf(bit sz, logic [45:0] a);
    logic [7:0] off = a[7:0];
    if (a[43:10] != 0) return 0;
    if (sz ? (off % 8 != 0) : (off % 4 != 0)) return 0;
    if (off == 8'h00) return 1;
    if (off == 8'h04) return 2;
    if (off == 8'h08) return 3;
    if (off == 8'h0C) return 4;
    if (off >= 8'h20 && off <= 8'h3F) return 5;
    return 0;
  endfunction

  function automatic string tagOf(bit sz, logic [45:0] a);
    int k = kindOf(sz, a);
    if (k == 0) return (sz ? (a[2:0] != 0) : (a[1:0] != 0)) ? "R8" : "R9";
    case (k)
      1: return "R5";
      2: return "R6";
      3: return "R3";
      4: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic access(input bit wr, input bit sz, input logic [45:0] a,
                        input logic [63:0] d, input string tagIn = "");
    int k = kindOf(sz, a);
    int idx = a[45:44] * 4 + a[9:8];
    int slot = idx * 4 + (a[7:0] - 8'h20) / 8;
    logic [63:0] expD = '0;
    logic [31:0] nv;
    string tag = (tagIn == "") ? tagOf(sz, a) : tagIn;
    if (!wr) begin
      case (k)
        1: expD = {32'd0, mStat[idx]};
        2: expD = {32'd0, mEn[idx]};
        5: expD = sz ? mMbx[slot] : (a[2] ? {32'd0, mMbx[slot][63:32]}
                                          : {32'd0, mMbx[slot][31:0]});
        default: expD = '0;
      endcase
    end
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = d;
    @(negedge clk);
    checks++;
    if (rspValid !== !wr || rspErr !== (k == 0) || (!wr && rspData !== expD)) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d: valid=%0b err=%0b data=%h, expected valid=%0b err=%0b data=%h",
               tag, a, wr, rspValid, rspErr, rspData, !wr, (k == 0), expD);
    end
    if (wr) begin
      case (k)
        2: mEn[idx] = d[31:0];
        3: begin mStat[idx] = mStat[idx] | d[31:0]; mIrq[idx] = 1'b1; end
        4: begin
          nv = mStat[idx] & ~d[31:0];
          mStat[idx] = nv;
          if (nv == 0) mIrq[idx] = 1'b0;
        end
        5: begin
          if (sz)        mMbx[slot] = d;
          else if (a[2]) mMbx[slot][63:32] = d[31:0];
          else           mMbx[slot][31:0] = d[31:0];
        end
        default: ;
      endcase
    end
    checks++;
    if (irq !== mIrq) begin
      errors++;
      $display("FAIL %s irq=%h expected %h (R2 index mapping)", tag, irq, mIrq);
    end
  endtask

  task automatic idle();
    reqValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    for (int i = 0; i < 16; i++) begin mStat[i] = '0; mEn[i] = '0; end
    for (int i = 0; i < 64; i++) mMbx[i] = '0;
    mIrq = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (irq !== 16'd0 || rspValid !== 1'b0 || rspErr !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset irq=%h valid=%0b err=%0b, expected 0 0 0", irq, rspValid, rspErr);
    end
    // R1: reset contents
    access(0, 0, mk(3, 3, 8'h00), 0, "R1");
    access(0, 0, mk(2, 1, 8'h04), 0, "R1");
    access(0, 1, mk(1, 2, 8'h38), 0, "R1");

    // R2/R3: set on node 1 core 1 -> index 5
    access(1, 0, mk(1, 1, 8'h08), 64'h5, "R2");
    access(0, 0, mk(1, 1, 8'h00), 0, "R3");
    // R3: set with zero data still raises the line
    access(1, 0, mk(0, 0, 8'h08), 64'h0, "R3");
    // R4: clear of an empty status drops the line
    access(1, 0, mk(0, 0, 8'h0C), 64'h0, "R4");
    // R4: partial clear keeps the line, full clear drops it
    access(1, 1, mk(3, 2, 8'h08), 64'hFFFF_0000_0000_00F0, "R3");
    access(1, 0, mk(3, 2, 8'h0C), 64'h30, "R4");
    access(1, 0, mk(3, 2, 8'h0C), 64'hC0, "R4");
    access(0, 0, mk(3, 2, 8'h00), 0, "R4");
    // R5: status write ignored, set/clear read zero
    access(1, 0, mk(1, 1, 8'h00), 64'hFFFF_FFFF, "R5");
    access(0, 0, mk(1, 1, 8'h00), 0, "R5");
    access(0, 1, mk(1, 1, 8'h08), 0, "R5");
    access(0, 0, mk(1, 1, 8'h0C), 0, "R5");
    // R6: enable stored, irq unaffected
    access(1, 0, mk(2, 0, 8'h04), 64'h1234_ABCD, "R6");
    access(0, 0, mk(2, 0, 8'h04), 0, "R6");
    access(1, 0, mk(1, 1, 8'h04), 64'h0, "R6");
    // R7: mailbox halves
    access(1, 1, mk(0, 3, 8'h28), 64'h1111_2222_3333_4444, "R7");
    access(1, 0, mk(0, 3, 8'h2C), 64'hDEAD_BEEF, "R7");
    access(0, 1, mk(0, 3, 8'h28), 0, "R7");
    access(1, 0, mk(0, 3, 8'h28), 64'h0000_0000_5A5A_5A5A, "R7");
    access(0, 0, mk(0, 3, 8'h2C), 0, "R7");
    access(0, 0, mk(0, 3, 8'h28), 0, "R7");
    // R8: misaligned access
    access(1, 1, mk(0, 3, 8'h2C), 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    access(0, 1, mk(0, 3, 8'h28), 0, "R8");
    access(1, 0, mk(2, 2, 8'h0A), 64'hF, "R8");
    access(0, 0, mk(0, 3, 8'h22), 0, "R8");
    // R9: unknown offset and outside window
    access(1, 0, mk(2, 2, 8'h10), 64'hF, "R9");
    access(0, 0, mk(2, 2, 8'h40), 0, "R9");
    access(1, 0, mk(2, 2, 8'h08) | (46'd1 << 10), 64'hF, "R9");
    access(0, 0, mk(2, 2, 8'h00), 0, "R9");
    // R10: set then clear back to back
    access(1, 0, mk(3, 0, 8'h08), 64'h9, "R10");
    access(1, 0, mk(3, 0, 8'h0C), 64'h9, "R10");
    idle();
    checks++;
    if (rspValid !== 1'b0 || rspErr !== 1'b0) begin
      errors++;
      $display("FAIL R10 idle valid=%0b err=%0b expected 0 0", rspValid, rspErr);
    end

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int n = $urandom % 4;
      int c = $urandom % 4;
      int r = $urandom % 12;
      int off;
      bit sz = $urandom % 2;
      bit wr = ($urandom % 10) < 6;
      logic [45:0] a;
      case (r)
        0: off = 8'h00;
        1: off = 8'h04;
        2, 3, 4: off = 8'h08;
        5, 6: off = 8'h0C;
        7, 8, 9: off = 8'h20 + ($urandom % 8) * 4;
        default: off = $urandom % 256;
      endcase
      a = mk(n, c, off);
      if ($urandom % 40 == 0) a[10 + ($urandom % 34)] = 1'b1;
      access(wr, sz, a, {$urandom, $urandom} & (($urandom % 3 == 0) ? 64'h0000_000F_0000_000F : '1));
      if ($urandom % 8 == 0) idle();
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule